// File: doc/BRIEF.md
# Register Window State Counter Manager

This block keeps the bookkeeping state of a windowed register file: how many windows may still be saved into, how many may be restored from, how many belong to another address space, and how many are known to be clean. Next to these four counters it holds a 6-bit window-state register that selects trap vectors, and the internal current-window pointer. The register storage itself lives elsewhere; this block only decides where the pointer goes and whether an operation may proceed.

A pipeline issues one command per cycle with a valid strobe. Window commands are save, restore, flush-windows, saved and restored. Each one either moves the counters and the pointer, or reports a trap with a computed trap code and leaves all state as it was. Two further commands load the counters and the window-state register, or write the architectural pointer. The architectural pointer counts in the opposite direction to the internal one, and the block presents it as a mirrored value. Every result is registered and appears one clock edge after the command.

Top module: `wsm_core`

## Requirements
- R1: After reset, cansave = NWIN-2, canrestore = 0, otherwin = 0, cleanwin = NWIN-1, wstate = 0, cwp = 0, and trap_valid = 0 with trap_code = 0.
- R2: A save (op 0) with cansave = 0 raises a trap with code 0x080 ORed with the field of R3. A trap leaves cansave, canrestore, otherwin, cleanwin, wstate and cwp unchanged.
- R3: The field that is ORed into spill and fill codes is 0x020 | (wstate[5:3] << 2) when otherwin is nonzero. It is wstate[2:0] << 2 when otherwin is 0.
- R4: A save with cansave != 0 but with cleanwin - canrestore = 0 (modulo the counter width) raises a trap with code 0x024.
- R5: Any other save decrements cansave, increments canrestore and decrements cwp. cwp wraps from 0 to NWIN-1.
- R6: A restore (op 1) with canrestore = 0 raises a trap with code 0x0C0 ORed with the field of R3. Otherwise it increments cansave, decrements canrestore and increments cwp, wrapping from NWIN-1 to 0.
- R7: A flush-windows (op 2) raises a trap coded as in R2 unless cansave = NWIN-2. In either case it changes no counter and not cwp.
- R8: A saved (op 3) increments cansave. It then decrements canrestore when otherwin = 0, and decrements otherwin otherwise.
- R9: A restored (op 4) increments canrestore, and increments cleanwin only while cleanwin < NWIN-1. It then decrements cansave when otherwin = 0, and decrements otherwin otherwise.
- R10: arch_cwp always equals NWIN-1-cwp. A pointer write (op 5) sets cwp to NWIN-1-(set_ptr_val mod NWIN).
- R11: A load (op 6) copies the ld_* inputs into the four counters and wstate. Op 7, or any op presented with cmd_valid low, changes no state.
- R12: trap_valid is high for exactly the cycle after a command that trapped, and trap_code is 0 whenever trap_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, at most one command per cycle |
| cmd_op | input | 3 | Command code (0 save, 1 restore, 2 flush, 3 saved, 4 restored, 5 pointer write, 6 load, 7 none) |
| set_ptr_val | input | 8 | Architectural pointer value for op 5 |
| ld_cansave | input | CW | Load value for cansave |
| ld_canrestore | input | CW | Load value for canrestore |
| ld_otherwin | input | CW | Load value for otherwin |
| ld_cleanwin | input | CW | Load value for cleanwin |
| ld_wstate | input | 6 | Load value for the window-state register |
| cansave | output | CW | Windows available to save into |
| canrestore | output | CW | Windows available to restore from |
| otherwin | output | CW | Windows owned by another address space |
| cleanwin | output | CW | Windows known to be clean |
| wstate | output | 6 | Window-state register |
| cwp | output | CW | Internal current-window pointer |
| arch_cwp | output | CW | Architectural (mirrored) pointer |
| trap_valid | output | 1 | A trap was raised by the previous command |
| trap_code | output | 9 | Trap type of the raised trap, 0 otherwise |

## Verification
The assertions assume nothing about the order or legality of commands. Counters wrap at their width, so the sum cansave+canrestore+otherwin, taken modulo 2^CW, is kept by every window command even when software issues a saved or restored that no real handler would issue. The pointer properties only assume that loads never touch cwp. The stimulus therefore mixes directed sequences, which run the window down to each trap boundary, with random commands and random loads of any value. This reaches wrap-around and otherwise illegal states without breaking any stated assumption.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    typedef enum logic [2:0] {
        OP_SAVE     = 3'd0,
        OP_RESTORE  = 3'd1,
        OP_FLUSHW   = 3'd2,
        OP_SAVED    = 3'd3,
        OP_RESTORED = 3'd4,
        OP_SETPTR   = 3'd5,
        OP_LOAD     = 3'd6,
        OP_NONE     = 3'd7
    } wsm_op_e;

    localparam int unsigned CODE_W = 9;

    localparam logic [CODE_W-1:0] CODE_SPILL = 9'h080;
    localparam logic [CODE_W-1:0] CODE_FILL  = 9'h0C0;
    localparam logic [CODE_W-1:0] CODE_OTHER = 9'h020;
    localparam logic [CODE_W-1:0] CODE_CLEAN = 9'h024;

endpackage

// File: rtl/wsm_trap_gen.sv
module wsm_trap_gen
    import wsm_pkg::*;
(
    input  logic              is_fill,
    input  logic              other_nz,
    input  logic [5:0]        wstate,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] field;

    always_comb begin
        base = is_fill ? CODE_FILL : CODE_SPILL;
        if (other_nz) begin
            field = CODE_OTHER | {4'b0, wstate[5:3], 2'b00};
        end else begin
            field = {4'b0, wstate[2:0], 2'b00};
        end
        code = base | field;
    end

endmodule

// File: rtl/wsm_cwp_unit.sv
module wsm_cwp_unit #(
    parameter  int NWIN = 8,
    localparam int CW   = $clog2(NWIN)
) (
    input  logic [CW-1:0] cwp,
    input  logic [7:0]    set_ptr_val,
    output logic [CW-1:0] cwp_inc,
    output logic [CW-1:0] cwp_dec,
    output logic [CW-1:0] cwp_from_arch,
    output logic [CW-1:0] arch_cwp
);

    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    generate
        if (NWIN == (1 << CW)) begin : g_pow2
            assign cwp_inc = cwp + 1'b1;
            assign cwp_dec = cwp - 1'b1;
        end else begin : g_cmp
            assign cwp_inc = (cwp == LAST) ? '0 : cwp + 1'b1;
            assign cwp_dec = (cwp == '0) ? LAST : cwp - 1'b1;
        end
    endgenerate

    logic [CW-1:0] wr_mod;

    assign wr_mod        = CW'(32'(set_ptr_val) % NWIN);
    assign cwp_from_arch = LAST - wr_mod;
    assign arch_cwp      = LAST - cwp;

endmodule

// File: rtl/wsm_counter_step.sv
module wsm_counter_step #(
    parameter  int NWIN = 8,
    localparam int CW   = $clog2(NWIN)
) (
    input  logic [CW-1:0] cansave,
    input  logic [CW-1:0] canrestore,
    input  logic [CW-1:0] otherwin,
    input  logic [CW-1:0] cleanwin,
    output logic          spill_hit,
    output logic          clean_hit,
    output logic          fill_hit,
    output logic          flush_hit,
    output logic [CW-1:0] saved_cansave,
    output logic [CW-1:0] saved_canrestore,
    output logic [CW-1:0] saved_otherwin,
    output logic [CW-1:0] rstd_cansave,
    output logic [CW-1:0] rstd_canrestore,
    output logic [CW-1:0] rstd_otherwin,
    output logic [CW-1:0] rstd_cleanwin
);

    localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);
    localparam logic [CW-1:0] FLUSH_OK  = CW'(NWIN - 2);

    logic other_zero;
    logic [CW-1:0] clean_gap;

    assign other_zero = (otherwin == '0);
    assign clean_gap  = cleanwin - canrestore;

    assign spill_hit = (cansave == '0);
    assign clean_hit = !spill_hit && (clean_gap == '0);
    assign fill_hit  = (canrestore == '0);
    assign flush_hit = (cansave != FLUSH_OK);

    always_comb begin
        saved_cansave    = cansave + 1'b1;
        saved_canrestore = canrestore;
        saved_otherwin   = otherwin;
        if (other_zero) begin
            saved_canrestore = canrestore - 1'b1;
        end else begin
            saved_otherwin = otherwin - 1'b1;
        end
    end

    always_comb begin
        rstd_canrestore = canrestore + 1'b1;
        rstd_cleanwin   = (cleanwin < CLEAN_MAX) ? cleanwin + 1'b1 : cleanwin;
        rstd_cansave    = cansave;
        rstd_otherwin   = otherwin;
        if (other_zero) begin
            rstd_cansave = cansave - 1'b1;
        end else begin
            rstd_otherwin = otherwin - 1'b1;
        end
    end

endmodule

// File: rtl/wsm_core.sv
module wsm_core
    import wsm_pkg::*;
#(
    parameter  int NWIN = 8,
    localparam int CW   = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [7:0]        set_ptr_val,
    input  logic [CW-1:0]     ld_cansave,
    input  logic [CW-1:0]     ld_canrestore,
    input  logic [CW-1:0]     ld_otherwin,
    input  logic [CW-1:0]     ld_cleanwin,
    input  logic [5:0]        ld_wstate,
    output logic [CW-1:0]     cansave,
    output logic [CW-1:0]     canrestore,
    output logic [CW-1:0]     otherwin,
    output logic [CW-1:0]     cleanwin,
    output logic [5:0]        wstate,
    output logic [CW-1:0]     cwp,
    output logic [CW-1:0]     arch_cwp,
    output logic              trap_valid,
    output logic [CODE_W-1:0] trap_code
);

    typedef struct packed {
        logic [CW-1:0]     cansave;
        logic [CW-1:0]     canrestore;
        logic [CW-1:0]     otherwin;
        logic [CW-1:0]     cleanwin;
        logic [5:0]        wstate;
        logic [CW-1:0]     cwp;
        logic              trap;
        logic [CODE_W-1:0] code;
    } wsm_state_t;

    wsm_state_t st_d, st_q;

    wsm_op_e op;
    assign op = wsm_op_e'(cmd_op);

    logic          spill_hit, clean_hit, fill_hit, flush_hit;
    logic [CW-1:0] sv_cs, sv_cr, sv_ow;
    logic [CW-1:0] rs_cs, rs_cr, rs_ow, rs_cw;
    logic [CW-1:0] cwp_inc, cwp_dec, cwp_from_arch;
    logic [CODE_W-1:0] spill_code, fill_code;

    wsm_counter_step #(.NWIN(NWIN)) u_step (
        .cansave          (st_q.cansave),
        .canrestore       (st_q.canrestore),
        .otherwin         (st_q.otherwin),
        .cleanwin         (st_q.cleanwin),
        .spill_hit        (spill_hit),
        .clean_hit        (clean_hit),
        .fill_hit         (fill_hit),
        .flush_hit        (flush_hit),
        .saved_cansave    (sv_cs),
        .saved_canrestore (sv_cr),
        .saved_otherwin   (sv_ow),
        .rstd_cansave     (rs_cs),
        .rstd_canrestore  (rs_cr),
        .rstd_otherwin    (rs_ow),
        .rstd_cleanwin    (rs_cw)
    );

    wsm_cwp_unit #(.NWIN(NWIN)) u_ptr (
        .cwp           (st_q.cwp),
        .set_ptr_val   (set_ptr_val),
        .cwp_inc       (cwp_inc),
        .cwp_dec       (cwp_dec),
        .cwp_from_arch (cwp_from_arch),
        .arch_cwp      (arch_cwp)
    );

    wsm_trap_gen u_spill (
        .is_fill  (1'b0),
        .other_nz (st_q.otherwin != '0),
        .wstate   (st_q.wstate),
        .code     (spill_code)
    );

    wsm_trap_gen u_fill (
        .is_fill  (1'b1),
        .other_nz (st_q.otherwin != '0),
        .wstate   (st_q.wstate),
        .code     (fill_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        st_d.code = '0;
        if (cmd_valid) begin
            unique case (op)
                OP_SAVE: begin
                    if (spill_hit) begin
                        st_d.trap = 1'b1;
                        st_d.code = spill_code;
                    end else if (clean_hit) begin
                        st_d.trap = 1'b1;
                        st_d.code = CODE_CLEAN;
                    end else begin
                        st_d.cansave    = st_q.cansave - 1'b1;
                        st_d.canrestore = st_q.canrestore + 1'b1;
                        st_d.cwp        = cwp_dec;
                    end
                end
                OP_RESTORE: begin
                    if (fill_hit) begin
                        st_d.trap = 1'b1;
                        st_d.code = fill_code;
                    end else begin
                        st_d.cansave    = st_q.cansave + 1'b1;
                        st_d.canrestore = st_q.canrestore - 1'b1;
                        st_d.cwp        = cwp_inc;
                    end
                end
                OP_FLUSHW: begin
                    if (flush_hit) begin
                        st_d.trap = 1'b1;
                        st_d.code = spill_code;
                    end
                end
                OP_SAVED: begin
                    st_d.cansave    = sv_cs;
                    st_d.canrestore = sv_cr;
                    st_d.otherwin   = sv_ow;
                end
                OP_RESTORED: begin
                    st_d.cansave    = rs_cs;
                    st_d.canrestore = rs_cr;
                    st_d.otherwin   = rs_ow;
                    st_d.cleanwin   = rs_cw;
                end
                OP_SETPTR: begin
                    st_d.cwp = cwp_from_arch;
                end
                OP_LOAD: begin
                    st_d.cansave    = ld_cansave;
                    st_d.canrestore = ld_canrestore;
                    st_d.otherwin   = ld_otherwin;
                    st_d.cleanwin   = ld_cleanwin;
                    st_d.wstate     = ld_wstate;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cansave    <= CW'(NWIN - 2);
            st_q.canrestore <= '0;
            st_q.otherwin   <= '0;
            st_q.cleanwin   <= CW'(NWIN - 1);
            st_q.wstate     <= '0;
            st_q.cwp        <= '0;
            st_q.trap       <= 1'b0;
            st_q.code       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cansave    = st_q.cansave;
    assign canrestore = st_q.canrestore;
    assign otherwin   = st_q.otherwin;
    assign cleanwin   = st_q.cleanwin;
    assign wstate     = st_q.wstate;
    assign cwp        = st_q.cwp;
    assign trap_valid = st_q.trap;
    assign trap_code  = st_q.code;

endmodule

// File: rtl/wsm_core_chk.sv
module wsm_core_chk
    import wsm_pkg::*;
#(
    parameter  int NWIN = 8,
    localparam int CW   = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [CW-1:0]     cansave,
    input logic [CW-1:0]     canrestore,
    input logic [CW-1:0]     otherwin,
    input logic [CW-1:0]     cleanwin,
    input logic [5:0]        wstate,
    input logic [CW-1:0]     cwp,
    input logic [CW-1:0]     arch_cwp,
    input logic              trap_valid,
    input logic [CODE_W-1:0] trap_code
);

    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    logic [CW-1:0] pair_sum;
    assign pair_sum = cansave + canrestore + otherwin;

    logic win_cmd;
    assign win_cmd = cmd_valid && (cmd_op inside {OP_SAVE, OP_RESTORE, OP_FLUSHW,
                                                  OP_SAVED, OP_RESTORED});

    // R2: a trap leaves every counter and the pointer where they were
    p_trap_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ($stable(cansave) && $stable(canrestore) && $stable(otherwin)
                        && $stable(cleanwin) && $stable(cwp) && $stable(wstate)));

    // R5: a save that passes both checks steps the pointer down with wrap
    p_save_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SAVE && cansave != '0 && cleanwin != canrestore)
        |=> (cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1)));

    // R7: flush-windows moves nothing
    p_flush_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FLUSHW)
        |=> ($stable(cansave) && $stable(canrestore) && $stable(otherwin)
             && $stable(cleanwin) && $stable(cwp)));

    // R8: window commands keep the modular pair sum
    p_pair_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_cmd |=> $stable(pair_sum));

    // R9: cleanwin saturates at NWIN-1 on restored
    p_clean_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RESTORED)
        |=> (cleanwin == (($past(cleanwin) < LAST) ? $past(cleanwin) + 1'b1
                                                    : $past(cleanwin))));

    // R10: pointer stays in range and the mirror sums to NWIN-1
    p_ptr_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cwp <= LAST) && (CW'(cwp + arch_cwp) == LAST));

    // R12: a trap appears only after a command and carries a nonzero code
    p_trap_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ($past(cmd_valid) && trap_code != '0));

    p_code_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_code == '0));

endmodule

bind wsm_core wsm_core_chk #(.NWIN(NWIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cansave    (cansave),
    .canrestore (canrestore),
    .otherwin   (otherwin),
    .cleanwin   (cleanwin),
    .wstate     (wstate),
    .cwp        (cwp),
    .arch_cwp   (arch_cwp),
    .trap_valid (trap_valid),
    .trap_code  (trap_code)
);

// File: tb/wsm_core_test.sv
module wsm_core_test;

    localparam int NW         = 8;
    localparam int CWB        = $clog2(NW);
    localparam int MSK        = (1 << CWB) - 1;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = 3'd7;
    logic [7:0]      set_ptr_val = '0;
    logic [CWB-1:0]  ld_cansave = '0, ld_canrestore = '0, ld_otherwin = '0, ld_cleanwin = '0;
    logic [5:0]      ld_wstate = '0;
    logic [CWB-1:0]  cansave, canrestore, otherwin, cleanwin, cwp, arch_cwp;
    logic [5:0]      wstate;
    logic            trap_valid;
    logic [8:0]      trap_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsm_core #(.NWIN(NW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .set_ptr_val(set_ptr_val), .ld_cansave(ld_cansave), .ld_canrestore(ld_canrestore),
        .ld_otherwin(ld_otherwin), .ld_cleanwin(ld_cleanwin), .ld_wstate(ld_wstate),
        .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
        .cleanwin(cleanwin), .wstate(wstate), .cwp(cwp), .arch_cwp(arch_cwp),
        .trap_valid(trap_valid), .trap_code(trap_code)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    int m_cs, m_cr, m_ow, m_cw, m_ws, m_cwp, m_tv, m_tt;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int trap_field();
        if (m_ow != 0) return 32'h20 | (((m_ws >> 3) & 7) << 2);
        return (m_ws & 7) << 2;
    endfunction

    task automatic model_reset();
        m_cs = NW - 2; m_cr = 0; m_ow = 0; m_cw = NW - 1;
        m_ws = 0; m_cwp = 0; m_tv = 0; m_tt = 0;
    endtask

    function automatic string model_step(bit v, int op, int pv,
                                         int lcs, int lcr, int low, int lcw, int lws);
        string tag;
        m_tv = 0; m_tt = 0; tag = "R11";
        if (!v) return tag;
        case (op)
            0: begin
                if (m_cs == 0) begin m_tv = 1; m_tt = 32'h80 | trap_field(); tag = "R2"; end
                else if (((m_cw - m_cr) & MSK) == 0) begin m_tv = 1; m_tt = 32'h24; tag = "R4"; end
                else begin
                    m_cs = (m_cs - 1) & MSK; m_cr = (m_cr + 1) & MSK;
                    m_cwp = (m_cwp + NW - 1) % NW; tag = "R5";
                end
            end
            1: begin
                tag = "R6";
                if (m_cr == 0) begin m_tv = 1; m_tt = 32'hC0 | trap_field(); end
                else begin
                    m_cs = (m_cs + 1) & MSK; m_cr = (m_cr - 1) & MSK;
                    m_cwp = (m_cwp + 1) % NW;
                end
            end
            2: begin
                tag = "R7";
                if (m_cs != NW - 2) begin m_tv = 1; m_tt = 32'h80 | trap_field(); end
            end
            3: begin
                tag = "R8";
                m_cs = (m_cs + 1) & MSK;
                if (m_ow == 0) m_cr = (m_cr - 1) & MSK;
                else m_ow = (m_ow - 1) & MSK;
            end
            4: begin
                tag = "R9";
                m_cr = (m_cr + 1) & MSK;
                if (m_cw < NW - 1) m_cw = m_cw + 1;
                if (m_ow == 0) m_cs = (m_cs - 1) & MSK;
                else m_ow = (m_ow - 1) & MSK;
            end
            5: begin tag = "R10"; m_cwp = NW - 1 - (pv % NW); end
            6: begin m_cs = lcs; m_cr = lcr; m_ow = low; m_cw = lcw; m_ws = lws; end
            default: ;
        endcase
        return tag;
    endfunction

    task automatic compare_all(string tag);
        check(tag, "cansave", int'(cansave), m_cs);
        check(tag, "canrestore", int'(canrestore), m_cr);
        check(tag, "otherwin", int'(otherwin), m_ow);
        check(tag, "cleanwin", int'(cleanwin), m_cw);
        check(tag, "wstate", int'(wstate), m_ws);
        check(tag, "cwp", int'(cwp), m_cwp);
        check("R10", "arch_cwp", int'(arch_cwp), NW - 1 - m_cwp);
        check("R12", "trap_valid", int'(trap_valid), m_tv);
        check(m_tv != 0 ? "R3" : "R12", "trap_code", int'(trap_code), m_tt);
    endtask

    task automatic cmd(bit v, int op, int pv = 0, int lcs = 0, int lcr = 0,
                       int low = 0, int lcw = 0, int lws = 0);
        string tag;
        @(negedge clk);
        cmd_valid = v; cmd_op = 3'(op); set_ptr_val = 8'(pv);
        ld_cansave = CWB'(lcs); ld_canrestore = CWB'(lcr);
        ld_otherwin = CWB'(low); ld_cleanwin = CWB'(lcw); ld_wstate = 6'(lws);
        tag = model_step(v, op, pv, lcs & MSK, lcr & MSK, low & MSK, lcw & MSK, lws & 63);
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all(tag);
    endtask

    task automatic load(int lcs, int lcr, int low, int lcw, int lws);
        cmd(1, 6, 0, lcs, lcr, low, lcw, lws);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all("R1");

        // R5: save until the spill boundary; pointer wraps 0 -> 7
        for (int i = 0; i < NW - 2; i++) cmd(1, 0);
        // R2: cansave is 0 now, otherwin 0, wstate 0 -> 0x080
        cmd(1, 0);
        // R7: flush with cansave 0 traps
        cmd(1, 2);
        // R6: restore back, pointer wraps 7 -> 0
        for (int i = 0; i < NW - 2; i++) cmd(1, 1);
        // R6: fill trap with canrestore 0
        cmd(1, 1);
        // R7: flush with cansave = NWIN-2 does not trap
        cmd(1, 2);

        // R3: otherwin zero selects wstate[2:0]
        load(0, 3, 0, 5, 6'b101_011);
        cmd(1, 0);
        cmd(1, 2);
        // R3: otherwin nonzero selects wstate[5:3] plus the other flag
        load(0, 0, 2, 5, 6'b110_001);
        cmd(1, 0);
        cmd(1, 1);
        // R4: clean-window trap when cleanwin equals canrestore
        load(2, 3, 1, 3, 0);
        cmd(1, 0);
        // R8: saved with otherwin nonzero, then zero
        cmd(1, 3);
        cmd(1, 3);
        // R9: restored below cap, at cap, with otherwin
        load(3, 1, 1, 6, 0);
        cmd(1, 4);
        cmd(1, 4);
        cmd(1, 4);
        // R10: pointer writes including values at and above NWIN
        cmd(1, 5, 0);
        cmd(1, 5, 7);
        cmd(1, 5, 13);
        cmd(1, 5, 255);
        // R11: op 7 and an invalid save change nothing
        cmd(1, 7);
        cmd(0, 0);
        cmd(0, 6, 0, 1, 1, 1, 1, 63);

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 7);
            cmd($urandom_range(0, 9) != 0, op, $urandom_range(0, 255),
                $urandom_range(0, MSK), $urandom_range(0, MSK),
                ($urandom_range(0, 2) == 0) ? $urandom_range(0, MSK) : 0,
                $urandom_range(0, MSK), $urandom_range(0, 63));
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule